// File: doc/BRIEF.md
# Parallel Port Slave to FIFO Bridge

This block is the peripheral end of an enhanced parallel port link. A host on the parallel bus runs three kinds of cycles against it. An address write loads an internal address register. A data write hands a byte, together with the current address, to downstream logic through two paired FIFO write ports. A data read sends the current address out on a request FIFO, waits for the answering byte on an input FIFO and then returns that byte on the bus. The host can also read back the address register with an address-strobe read.

Both host strobes are asynchronous and active low. Each strobe passes through a synchroniser and then a two-bit history register, which yields rising and falling edge pulses. A single state machine sequences every cycle. The machine raises the wait line once the transfer is complete and drops it again after the host releases its strobe. The bus is split into an input byte, an output byte and an output enable, and the pad driver sits outside this block.

Top module: `epp_fifo_bridge`

## Requirements
- R1: After reset the wait line is low, the bus output enable is low, no FIFO enable is active, and the address register reads back as zero.
- R2: After a strobe goes low and the transfer completes, the wait line goes high. It stays high for as long as the host holds the strobe low, and it returns low within a few cycles after the strobe goes high.
- R3: An address write (address strobe low with write_n low) stores the bus byte in the address register. An address read (address strobe low with write_n high) returns that register, zero-extended, on bus_dout. Data cycles leave the register unchanged.
- R4: A data write (data strobe low with write_n low) produces exactly one single-cycle pulse of wr_en. During that pulse, wr_data holds the bus byte and wr_addr holds the current address.
- R5: A data read (data strobe low with write_n high) produces exactly one single-cycle pulse of rq_en, with rq_addr equal to the current address. This pulse comes before any pop of the input FIFO.
- R6: While the input FIFO is empty (rd_empty high), a pending read keeps the wait line low. Once the FIFO is non-empty, the wait line rises and bus_dout carries the FIFO head byte.
- R7: Each read cycle pops the input FIFO exactly once, with a single-cycle rd_en pulse.
- R8: bus_oe is high only during a read, only after the byte is ready, and only while the strobe of that read is still low. It is never high during a write.
- R9: The level of write_n at the strobe's falling edge alone selects between write (0) and read (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| astb_n | input | 1 | Host address strobe, active low, asynchronous |
| dstb_n | input | 1 | Host data strobe, active low, asynchronous |
| write_n | input | 1 | Host direction: 0 write, 1 read |
| bus_din | input | DATA_W | Byte driven by the host |
| bus_dout | output | DATA_W | Byte returned to the host on reads |
| bus_oe | output | 1 | Enable for the external bus driver |
| host_wait | output | 1 | Handshake line back to the host |
| wr_en | output | 1 | Push pulse shared by the data and address output FIFOs |
| wr_data | output | DATA_W | Byte for the output data FIFO |
| wr_addr | output | ADDR_W | Address for the output address FIFO |
| rq_en | output | 1 | Push pulse for the read request FIFO |
| rq_addr | output | ADDR_W | Address being requested |
| rd_data | input | DATA_W | Head byte of the input FIFO |
| rd_empty | input | 1 | Input FIFO empty flag |
| rd_en | output | 1 | Pop pulse for the input FIFO |

## Verification
The bench starts reads with the input FIFO empty and holds them there for many cycles. A design that acknowledged too early would raise wait and return a stale byte, and one that polled the FIFO badly would pop it more than once or pop it before the request was pushed. Writes are checked for a single shared push that carries the address latched in the previous address cycle, which catches unpaired or doubled pushes and a stale address. Strobes are held low well past the acknowledge to show that wait does not drop early and that the bus driver turns off on release, never during a write.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ADDR_WR = 3'd1,
      ST_DATA_WR = 3'd2,
      ST_RD_REQ  = 3'd3,
      ST_RD_WAIT = 3'd4,
      ST_ACK     = 3'd5
   } bridge_state_t;

   localparam int STROBE_ADDR = 0;
   localparam int STROBE_DATA = 1;
   localparam int NUM_STROBES = 2;

endpackage

// File: rtl/epp_strobe_edge.sv
module epp_strobe_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall,
   output logic rise
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [1:0]             hist_q;
   logic                   synced;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("epp_strobe_edge: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= strobe_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n};
         end
      end
   endgenerate

   assign synced = sync_q[SYNC_STAGES-1];

   // history: bit 1 older sample, bit 0 newer sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 2'b11;
      else        hist_q <= {hist_q[0], synced};
   end

   assign fall = hist_q[1] & ~hist_q[0];
   assign rise = ~hist_q[1] & hist_q[0];

endmodule

// File: rtl/epp_bridge_fsm.sv
module epp_bridge_fsm
   import epp_bridge_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_fall,
   input  logic              a_rise,
   input  logic              d_fall,
   input  logic              d_rise,
   input  logic              write_n,
   input  logic [DATA_W-1:0] bus_din,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_empty,
   output logic              host_wait,
   output logic              drive,
   output logic              sel_addr,
   output logic [DATA_W-1:0] out_byte,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rq_en,
   output logic [ADDR_W-1:0] rq_addr,
   output logic              rd_en
);

   bridge_state_t     state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] cap_q;
   logic              sel_q;
   logic              drive_q;
   logic [DATA_W-1:0] out_q;
   logic              data_avail;
   logic              rel_edge;

   assign data_avail = ~rd_empty;
   assign rel_edge   = sel_q ? a_rise : d_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cap_q   <= '0;
         sel_q   <= 1'b0;
         drive_q <= 1'b0;
         out_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (a_fall) begin
                  sel_q <= 1'b1;
                  cap_q <= bus_din;
                  if (write_n) begin
                     out_q   <= DATA_W'(addr_q);
                     drive_q <= 1'b1;
                     state_q <= ST_ACK;
                  end else begin
                     state_q <= ST_ADDR_WR;
                  end
               end else if (d_fall) begin
                  sel_q   <= 1'b0;
                  cap_q   <= bus_din;
                  state_q <= write_n ? ST_RD_REQ : ST_DATA_WR;
               end
            end
            ST_ADDR_WR: begin
               addr_q  <= cap_q[ADDR_W-1:0];
               state_q <= ST_ACK;
            end
            ST_DATA_WR: state_q <= ST_ACK;
            ST_RD_REQ:  state_q <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (data_avail) begin
                  out_q   <= rd_data;
                  drive_q <= 1'b1;
                  state_q <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (rel_edge) begin
                  drive_q <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign host_wait = (state_q == ST_ACK);
   assign drive     = drive_q;
   assign sel_addr  = sel_q;
   assign out_byte  = out_q;
   assign wr_en     = (state_q == ST_DATA_WR);
   assign wr_data   = cap_q;
   assign wr_addr   = addr_q;
   assign rq_en     = (state_q == ST_RD_REQ);
   assign rq_addr   = addr_q;
   assign rd_en     = (state_q == ST_RD_WAIT) & data_avail;

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R4
   AST_RQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rq_en |=> !rq_en); // R5
   AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en); // R7
   AST_POP_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> host_wait); // R6
   AST_REQ_NOT_POP: assert property (@(posedge clk) disable iff (!rst_n)
      rq_en |-> !rd_en); // R5
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wait && !rel_edge) |=> host_wait); // R2
   AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_ADDR_WR) |=> $stable(addr_q)); // R3

endmodule

// File: rtl/epp_fifo_bridge.sv
module epp_fifo_bridge
   import epp_bridge_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              astb_n,
   input  logic              dstb_n,
   input  logic              write_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   output logic              host_wait,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rq_en,
   output logic [ADDR_W-1:0] rq_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_empty,
   output logic              rd_en
);

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("epp_fifo_bridge: ADDR_W must lie in 1..DATA_W");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("epp_fifo_bridge: DATA_W must be positive");
      end
   endgenerate

   logic [NUM_STROBES-1:0] strobe_n_v;
   logic [NUM_STROBES-1:0] fall_v;
   logic [NUM_STROBES-1:0] rise_v;
   logic                   drive;
   logic                   sel_addr;
   logic                   active_low;

   assign strobe_n_v[STROBE_ADDR] = astb_n;
   assign strobe_n_v[STROBE_DATA] = dstb_n;

   for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
      epp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .strobe_n (strobe_n_v[g]),
         .fall     (fall_v[g]),
         .rise     (rise_v[g])
      );
   end

   epp_bridge_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_fall    (fall_v[STROBE_ADDR]),
      .a_rise    (rise_v[STROBE_ADDR]),
      .d_fall    (fall_v[STROBE_DATA]),
      .d_rise    (rise_v[STROBE_DATA]),
      .write_n   (write_n),
      .bus_din   (bus_din),
      .rd_data   (rd_data),
      .rd_empty  (rd_empty),
      .host_wait (host_wait),
      .drive     (drive),
      .sel_addr  (sel_addr),
      .out_byte  (bus_dout),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_addr   (wr_addr),
      .rq_en     (rq_en),
      .rq_addr   (rq_addr),
      .rd_en     (rd_en)
   );

   assign active_low = sel_addr ? ~astb_n : ~dstb_n;
   assign bus_oe     = drive & active_low;

   AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> host_wait); // R8
   AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !bus_oe); // R8

endmodule

// File: tb/sim_epp_fifo_bridge.sv
module sim_epp_fifo_bridge;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       astb_n = 1'b1;
   logic       dstb_n = 1'b1;
   logic       write_n = 1'b1;
   logic [7:0] bus_din = '0;
   logic [7:0] bus_dout;
   logic       bus_oe;
   logic       host_wait;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] wr_addr;
   logic       rq_en;
   logic [7:0] rq_addr;
   logic [7:0] rd_data;
   logic       rd_empty;
   logic       rd_en;

   always #10ns clk = ~clk;

   epp_fifo_bridge u0 (
      .clk(clk), .rst_n(rst_n), .astb_n(astb_n), .dstb_n(dstb_n),
      .write_n(write_n), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_oe(bus_oe), .host_wait(host_wait), .wr_en(wr_en),
      .wr_data(wr_data), .wr_addr(wr_addr), .rq_en(rq_en),
      .rq_addr(rq_addr), .rd_data(rd_data), .rd_empty(rd_empty),
      .rd_en(rd_en)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // input FIFO model
   logic [7:0] fmem [0:15];
   int wptr = 0;
   int rptr = 0;
   assign rd_empty = (wptr == rptr);
   assign rd_data  = fmem[rptr % 16];
   always @(posedge clk) if (rd_en && !rd_empty) rptr <= rptr + 1;

   // monitors
   int n_wr = 0, n_rq = 0, n_pop = 0, n_oe_bad = 0;
   logic [7:0] last_wd, last_wa, last_ra;
   bit pop_before_req = 0;
   bit in_write = 0;
   always @(negedge clk) begin
      if (wr_en) begin n_wr++; last_wd = wr_data; last_wa = wr_addr; end
      if (rq_en) begin n_rq++; last_ra = rq_addr; end
      if (rd_en) begin
         n_pop++;
         if (n_pop > n_rq) pop_before_req = 1;
      end
      if (bus_oe && (in_write || (astb_n && dstb_n))) n_oe_bad++;
   end

   logic [7:0] model_addr = 8'h00;

   function automatic logic [7:0] exp_readback(input logic [7:0] a);
      return a;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_for_wait(input bit lvl, input int lim, output bit ok);
      ok = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (host_wait == lvl) begin ok = 1; break; end
      end
   endtask

   // generic handshake; returns byte seen and oe while strobe held
   task automatic cycle(input bit use_addr, input bit wr, input logic [7:0] d,
                        input string req, output logic [7:0] seen, output bit oe_seen);
      bit ok;
      @(negedge clk);
      write_n = ~wr;
      bus_din = d;
      in_write = wr;
      if (use_addr) astb_n = 0; else dstb_n = 0;
      wait_for_wait(1'b1, 60, ok);
      chk(ok, req, "wait rise", host_wait, 1);
      seen = bus_dout;
      oe_seen = bus_oe;
      repeat (4) @(negedge clk);
      chk(host_wait == 1'b1, "R2", "wait held while strobe low", host_wait, 1);
      astb_n = 1; dstb_n = 1;
      @(negedge clk);
      chk(bus_oe == 1'b0, "R8", "oe after release", bus_oe, 0);
      wait_for_wait(1'b0, 20, ok);
      chk(ok, "R2", "wait fall after release", host_wait, 0);
      in_write = 0;
      write_n = 1;
   endtask

   task automatic addr_write(input logic [7:0] a);
      logic [7:0] s; bit o;
      int w0 = n_wr, q0 = n_rq;
      cycle(1, 1, a, "R3", s, o);
      model_addr = a;
      chk(n_wr == w0 && n_rq == q0, "R9", "no fifo push on addr write", n_wr - w0, 0);
   endtask

   task automatic addr_read();
      logic [7:0] s; bit o;
      cycle(1, 0, 8'hA5, "R3", s, o);
      chk(s == exp_readback(model_addr), "R3", "addr readback", s, exp_readback(model_addr));
      chk(o == 1'b1, "R8", "oe during addr read", o, 1);
   endtask

   task automatic data_write(input logic [7:0] d);
      logic [7:0] s; bit o;
      int w0 = n_wr, q0 = n_rq;
      cycle(0, 1, d, "R4", s, o);
      chk(n_wr == w0 + 1, "R4", "one push", n_wr - w0, 1);
      chk(last_wd == d, "R4", "wr_data", last_wd, d);
      chk(last_wa == model_addr, "R4", "wr_addr", last_wa, model_addr);
      chk(n_rq == q0, "R9", "no request on write", n_rq - q0, 0);
   endtask

   task automatic push_fifo(input logic [7:0] d);
      @(negedge clk);
      fmem[wptr % 16] = d;
      wptr = wptr + 1;
   endtask

   task automatic data_read(input logic [7:0] d);
      logic [7:0] s; bit o;
      int q0 = n_rq, p0 = n_pop;
      push_fifo(d);
      cycle(0, 0, 8'h3C, "R6", s, o);
      chk(s == d, "R6", "read byte", s, d);
      chk(o == 1'b1, "R8", "oe during read", o, 1);
      chk(n_rq == q0 + 1, "R5", "one request", n_rq - q0, 1);
      chk(last_ra == model_addr, "R5", "rq_addr", last_ra, model_addr);
      chk(n_pop == p0 + 1, "R7", "one pop", n_pop - p0, 1);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      bit ok;
      int q0, p0;
      void'($urandom(32'h0000_5EED));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(host_wait == 0 && bus_oe == 0, "R1", "wait/oe in reset", {host_wait, bus_oe}, 0);
      chk(wr_en == 0 && rq_en == 0 && rd_en == 0, "R1", "enables in reset",
          {wr_en, rq_en, rd_en}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(host_wait == 0, "R1", "wait after reset", host_wait, 0);
      addr_read();                      // R1: register reads zero
      // directed
      addr_write(8'h5A);
      addr_read();
      data_write(8'hC3);
      data_read(8'h7E);
      addr_read();                      // R3: data cycles kept the address
      addr_write(8'hFF);
      data_write(8'h00);
      // R6 stall with empty FIFO
      q0 = n_rq; p0 = n_pop;
      @(negedge clk);
      write_n = 1; dstb_n = 0;
      repeat (40) @(negedge clk);
      chk(host_wait == 0, "R6", "wait low while empty", host_wait, 0);
      chk(bus_oe == 0, "R8", "oe low while empty", bus_oe, 0);
      chk(n_rq == q0 + 1 && last_ra == model_addr, "R5", "request during stall", n_rq - q0, 1);
      chk(n_pop == p0, "R7", "no pop while empty", n_pop - p0, 0);
      fmem[wptr % 16] = 8'h96;
      wptr = wptr + 1;
      wait_for_wait(1'b1, 40, ok);
      chk(ok && bus_dout == 8'h96, "R6", "byte after stall", bus_dout, 8'h96);
      chk(bus_oe == 1, "R8", "oe after stall", bus_oe, 1);
      repeat (3) @(negedge clk);
      dstb_n = 1;
      wait_for_wait(1'b0, 20, ok);
      chk(ok, "R2", "release after stall", host_wait, 0);
      chk(n_pop == p0 + 1, "R7", "single pop after stall", n_pop - p0, 1);
      // random mix
      for (int k = 0; k < 60; k++) begin
         int op;
         logic [7:0] v;
         op = $urandom_range(0, 3);
         v = 8'($urandom);
         case (op)
            0: addr_write(v);
            1: data_write(v);
            2: data_read(v);
            default: addr_read();
         endcase
      end
      chk(pop_before_req == 0, "R5", "pop never ahead of request", pop_before_req, 0);
      chk(n_oe_bad == 0, "R8", "oe outside read strobe", n_oe_bad, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule